// File: doc/BRIEF.md
# Card Command Issue and Response Sequencer

This block sits between a processor register port and a card interface engine. Software loads a command index and a 32-bit argument, then writes a command/data control word. The sequencer hands the command to the card interface, holds it there until the interface reports completion with a response byte count, and judges that count against the response type chosen in the control word. A long enough response is packed two bytes per 16-bit entry into a nine-entry response store. Software drains that store one entry per read.

A command can be requested while the card clock is stopped. The request is then held and goes out on a later clock-start write, provided the control word still allows it. Each completed command gives an end-of-command pulse. A command that asks for a data phase also gives a start pulse to the data engine, and the transfer stays marked active until that engine reports it finished or software cancels it.

Top module: `cmdseq_top`

## Requirements
- R1: After reset the status word reads 0, the active flag and the command-valid output are low, and a read of the response address returns 0.
- R2: The command index register keeps 6 bits of a write. A read returns the stored index with bit 6 set.
- R3: The argument high half (address 4) and low half (address 5) are written separately, and each write changes only its own 16 bits of the argument.
- R4: A write to the control register (address 2) stores the written value under mask 0x3DFF, reads back as stored, clears the active flag and marks a command as pending.
- R5: A control write with stop bit 10 clear, made while status bit 8 (clock enabled) is set, starts the command at that write. Command-valid is high from the next cycle, carrying the index and argument held at that moment, and the active flag is set.
- R6: A request made while the clock is off stays pending. A write to the clock address (address 0) with start bit 1 set and stop bit 0 clear sets status bit 8 and launches the pending command, but only if stored control bit 10 is clear.
- R7: Starting a command clears every status bit except bit 8.
- R8: Control bits 1:0 give the response type. Type 0 needs no bytes, types 1 and 3 need at least 4 bytes, and type 2 needs at least 16. A shorter count sets status bit 1, clears the active flag, gives no data start, and leaves the response store and its read position unchanged.
- R9: An accepted response sets status bit 13 and rewrites all nine entries. Entry i holds byte 2i in bits 7:0 and byte 2i+1 in bits 15:8. Bytes at or beyond the count are zero, and for type 0 every entry is zero.
- R10: Each read of the response address (6) returns the next entry, starting from entry 0 after an accepted response. Once nine entries have been read, further reads return 0.
- R11: Each completed command, accepted or timed out, gives exactly one end-of-command pulse.
- R12: An accepted response with control bit 2 clear ends the command with the active flag low. With bit 2 set, a one-cycle data-start pulse comes with the end pulse, and the active flag stays high until the data-finished input is pulsed.
- R13: Only one command is outstanding at a time. While command-valid is high, further control writes start nothing, and the index and argument outputs hold until completion.
- R14: A clock-address write with bit 0 set clears status bit 8 and the active flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered one cycle after bus_re |
| card_cmd_valid | output | 1 | Command outstanding at the card interface |
| card_idx | output | 6 | Command index of the outstanding command |
| card_arg | output | 32 | Argument of the outstanding command |
| card_done | input | 1 | Completion strobe from the card interface |
| card_rsp_len | input | 5 | Response byte count, valid with card_done |
| card_rsp_bytes | input | 144 | Response bytes, byte k in bits 8k+7:8k |
| end_evt | output | 1 | End-of-command pulse |
| data_go | output | 1 | Data phase start pulse |
| data_write | output | 1 | Stored control bit 3, data direction for the data engine |
| data_fin | input | 1 | Data engine finished pulse |
| xfer_active | output | 1 | Transfer active flag |

## Verification
Commands are launched by both routes: a control write with the clock already running, and a control write with the clock off followed by a clock start. A scoreboard matches each command seen at the card interface against the expected index and argument. The bench sends byte counts just below and exactly at each type's minimum, plus a type-0 command with stray bytes, so the bench can tell a wrongly chosen threshold from a wrong packing or a missing clear. Control writes made while a command is waiting, and stop bits set in the control word or in the clock write, confirm that no extra command goes out and that cancellation clears the active flag without a false data start.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

   typedef enum logic {SQ_IDLE, SQ_WAIT} sq_state_t;

   // register word addresses
   localparam logic [3:0] ADR_CLK   = 4'd0;
   localparam logic [3:0] ADR_STAT  = 4'd1;
   localparam logic [3:0] ADR_CTRL  = 4'd2;
   localparam logic [3:0] ADR_IDX   = 4'd3;
   localparam logic [3:0] ADR_ARGHI = 4'd4;
   localparam logic [3:0] ADR_ARGLO = 4'd5;
   localparam logic [3:0] ADR_RSP   = 4'd6;

   // status bit positions
   localparam int ST_TOUT = 1;
   localparam int ST_CLK  = 8;
   localparam int ST_END  = 13;

   // control word bit positions
   localparam int CT_DEN  = 2;
   localparam int CT_DIR  = 3;
   localparam int CT_STOP = 10;
   localparam logic [15:0] CTRL_KEEP = 16'h3DFF;

   // clock write bits
   localparam int CK_STOP  = 0;
   localparam int CK_START = 1;

   function automatic logic rsp_len_ok(input logic [1:0] typ, input int len,
                                       input int short_min, input int long_min);
      logic ok;
      case (typ)
         2'd0:    ok = 1'b1;
         2'd2:    ok = (len >= long_min);
         default: ok = (len >= short_min);
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/cmdseq_regs.sv
module cmdseq_regs #(
   parameter int DW     = 16,
   parameter int IDX_W  = 6,
   parameter int ARG_W  = 32,
   parameter int CTRL_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_idx,
   input  logic              wr_arg_hi,
   input  logic              wr_arg_lo,
   input  logic              wr_ctrl,
   input  logic [DW-1:0]     wdata,
   output logic [IDX_W-1:0]  idx_q,
   output logic [ARG_W-1:0]  arg_q,
   output logic [CTRL_W-1:0] ctrl_q
);
   import cmdseq_pkg::*;

   localparam int HALF_W = ARG_W / 2;

   if (ARG_W != 2 * DW) begin : g_bad_arg
      $error("argument must be two bus words wide");
   end
   if (CTRL_W > DW) begin : g_bad_ctrl
      $error("control word wider than the bus");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         arg_q  <= '0;
         ctrl_q <= '0;
      end else begin
         if (wr_idx)
            idx_q <= wdata[IDX_W-1:0];
         if (wr_arg_hi)
            arg_q[ARG_W-1:HALF_W] <= wdata;
         if (wr_arg_lo)
            arg_q[HALF_W-1:0] <= wdata;
         if (wr_ctrl)
            ctrl_q <= wdata[CTRL_W-1:0] & CTRL_KEEP[CTRL_W-1:0];
      end
   end

   // R3: a high-half write leaves the low half untouched
   AST_ARG_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_arg_hi && !wr_arg_lo) |=> $stable(arg_q[HALF_W-1:0])); // R3

endmodule

// File: rtl/cmdseq_ctrl.sv
module cmdseq_ctrl #(
   parameter int DW        = 16,
   parameter int IDX_W     = 6,
   parameter int ARG_W     = 32,
   parameter int LEN_W     = 5,
   parameter int SHORT_MIN = 4,
   parameter int LONG_MIN  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_clk,
   input  logic              ck_start,
   input  logic              ck_stop,
   input  logic              wr_ctrl,
   input  logic              new_stop,
   input  logic [1:0]        new_type,
   input  logic              new_den,
   input  logic              ctrl_stop_q,
   input  logic [1:0]        ctrl_type_q,
   input  logic              ctrl_den_q,
   input  logic [IDX_W-1:0]  idx_q,
   input  logic [ARG_W-1:0]  arg_q,
   input  logic              card_done,
   input  logic [LEN_W-1:0]  card_rsp_len,
   input  logic              data_fin,
   output logic              card_cmd_valid,
   output logic [IDX_W-1:0]  card_idx,
   output logic [ARG_W-1:0]  card_arg,
   output logic [DW-1:0]     status,
   output logic              active,
   output logic              end_evt,
   output logic              data_go,
   output logic              rsp_load,
   output logic [LEN_W-1:0]  rsp_load_len
);
   import cmdseq_pkg::*;

   localparam logic [DW-1:0] CLK_ONLY = DW'(1) << ST_CLK;

   if (ST_END >= DW) begin : g_bad_stat
      $error("status word too narrow");
   end
   if (SHORT_MIN > LONG_MIN) begin : g_bad_min
      $error("short minimum exceeds long minimum");
   end

   sq_state_t   state;
   logic        pending;
   logic [1:0]  lat_type;
   logic        lat_den;
   logic        launch, launch_by_ctrl, launch_by_clk;
   logic        take, rsp_ok, cancel;
   logic [DW-1:0] st_n;

   assign card_cmd_valid = (state == SQ_WAIT);

   assign launch_by_ctrl = wr_ctrl && !new_stop && status[ST_CLK];
   assign launch_by_clk  = wr_clk && ck_start && !ck_stop && pending && !ctrl_stop_q;
   assign launch         = (state == SQ_IDLE) && (launch_by_ctrl || launch_by_clk);

   assign take   = (state == SQ_WAIT) && card_done;
   assign rsp_ok = rsp_len_ok(lat_type, int'(card_rsp_len), SHORT_MIN, LONG_MIN);
   assign cancel = wr_ctrl || (wr_clk && ck_stop) || data_fin;

   assign rsp_load     = take && rsp_ok;
   assign rsp_load_len = (lat_type == 2'd0) ? '0 : card_rsp_len;

   always_comb begin
      st_n = status;
      if (wr_clk && ck_start) st_n[ST_CLK] = 1'b1;
      if (wr_clk && ck_stop)  st_n[ST_CLK] = 1'b0;
      if (launch)             st_n = st_n & CLK_ONLY;
      if (take) begin
         if (rsp_ok) st_n[ST_END]  = 1'b1;
         else        st_n[ST_TOUT] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         pending  <= 1'b0;
         lat_type <= 2'd0;
         lat_den  <= 1'b0;
         card_idx <= '0;
         card_arg <= '0;
         status   <= '0;
         active   <= 1'b0;
         end_evt  <= 1'b0;
         data_go  <= 1'b0;
      end else begin
         status  <= st_n;
         end_evt <= take;
         data_go <= take && rsp_ok && lat_den && active && !cancel;

         if (launch)       pending <= 1'b0;
         else if (wr_ctrl) pending <= 1'b1;

         if (launch) begin
            state    <= SQ_WAIT;
            card_idx <= idx_q;
            card_arg <= arg_q;
            lat_type <= wr_ctrl ? new_type : ctrl_type_q;
            lat_den  <= wr_ctrl ? new_den  : ctrl_den_q;
         end else if (take) begin
            state <= SQ_IDLE;
         end

         if (launch)
            active <= 1'b1;
         else if (cancel || (take && (!rsp_ok || !lat_den)))
            active <= 1'b0;
      end
   end

   AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (card_cmd_valid && !card_done) |=> (card_cmd_valid && $stable(card_idx) && $stable(card_arg))); // R13
   AST_END_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (card_cmd_valid && card_done) |=> end_evt); // R11
   AST_GO_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
      data_go |-> end_evt); // R12
   AST_LAUNCH_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_cmd_valid) |-> ((status & ~CLK_ONLY) == '0)); // R7
   AST_LAUNCH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_cmd_valid) |-> (active && status[ST_CLK])); // R5
   AST_TOUT_XOR_END: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[ST_TOUT] && status[ST_END])); // R8

endmodule

// File: rtl/cmdseq_rspfifo.sv
module cmdseq_rspfifo #(
   parameter int ENTRIES = 9,
   parameter int EW      = 16,
   parameter int LEN_W   = 5,
   localparam int BPE    = EW / 8,
   localparam int NBYTES = ENTRIES * BPE,
   localparam int PTR_W  = $clog2(ENTRIES + 1),
   localparam int SEL_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LEN_W-1:0]  load_len,
   input  logic [NBYTES*8-1:0] rsp_bytes,
   input  logic              pop,
   output logic [EW-1:0]     head
);
   if (EW % 8 != 0) begin : g_bad_ew
      $error("entry width must be whole bytes");
   end
   if ((1 << LEN_W) <= NBYTES) begin : g_bad_len
      $error("length field cannot count a full response");
   end

   logic [EW-1:0]    mem  [ENTRIES];
   logic [EW-1:0]    fill [ENTRIES];
   logic [PTR_W-1:0] rptr;

   for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
      for (genvar gj = 0; gj < BPE; gj++) begin : g_byte
         localparam int POS = gi * BPE + gj;
         assign fill[gi][gj*8 +: 8] = (POS < int'(load_len)) ? rsp_bytes[POS*8 +: 8] : 8'h00;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr <= PTR_W'(ENTRIES);
         for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
      end else if (load) begin
         rptr <= '0;
         for (int i = 0; i < ENTRIES; i++) mem[i] <= fill[i];
      end else if (pop && (rptr < PTR_W'(ENTRIES))) begin
         rptr <= rptr + 1'b1;
      end
   end

   assign head = (rptr < PTR_W'(ENTRIES)) ? mem[SEL_W'(rptr)] : '0;

   AST_RPTR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      rptr <= PTR_W'(ENTRIES)); // R10
   AST_LOAD_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (rptr == '0)); // R10
   AST_DRAINED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rptr == PTR_W'(ENTRIES)) |-> (head == '0)); // R10

endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top #(
   parameter int DW          = 16,
   parameter int IDX_W       = 6,
   parameter int ARG_W       = 32,
   parameter int CTRL_W      = 14,
   parameter int RSP_ENTRIES = 9,
   parameter int SHORT_MIN   = 4,
   parameter int LONG_MIN    = 16,
   localparam int NBYTES     = RSP_ENTRIES * DW / 8,
   localparam int LEN_W      = $clog2(NBYTES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic                bus_re,
   input  logic [3:0]          bus_addr,
   input  logic [DW-1:0]       bus_wdata,
   output logic [DW-1:0]       bus_rdata,
   output logic                card_cmd_valid,
   output logic [IDX_W-1:0]    card_idx,
   output logic [ARG_W-1:0]    card_arg,
   input  logic                card_done,
   input  logic [LEN_W-1:0]    card_rsp_len,
   input  logic [NBYTES*8-1:0] card_rsp_bytes,
   output logic                end_evt,
   output logic                data_go,
   output logic                data_write,
   input  logic                data_fin,
   output logic                xfer_active
);
   import cmdseq_pkg::*;

   if (IDX_W >= DW) begin : g_bad_idx
      $error("index flag bit does not fit the bus");
   end
   if (LONG_MIN > NBYTES) begin : g_bad_store
      $error("response store smaller than the long response");
   end

   logic wr_clk, wr_ctrl, wr_idx, wr_hi, wr_lo, pop;
   logic [IDX_W-1:0]  idx_q;
   logic [ARG_W-1:0]  arg_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [DW-1:0]     status, head;
   logic              rsp_load;
   logic [LEN_W-1:0]  rsp_load_len;
   logic [DW-1:0]     rd_n;

   assign wr_clk  = bus_we && (bus_addr == ADR_CLK);
   assign wr_ctrl = bus_we && (bus_addr == ADR_CTRL);
   assign wr_idx  = bus_we && (bus_addr == ADR_IDX);
   assign wr_hi   = bus_we && (bus_addr == ADR_ARGHI);
   assign wr_lo   = bus_we && (bus_addr == ADR_ARGLO);
   assign pop     = bus_re && (bus_addr == ADR_RSP);

   cmdseq_regs #(.DW(DW), .IDX_W(IDX_W), .ARG_W(ARG_W), .CTRL_W(CTRL_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_idx(wr_idx), .wr_arg_hi(wr_hi), .wr_arg_lo(wr_lo), .wr_ctrl(wr_ctrl),
      .wdata(bus_wdata),
      .idx_q(idx_q), .arg_q(arg_q), .ctrl_q(ctrl_q)
   );

   cmdseq_ctrl #(.DW(DW), .IDX_W(IDX_W), .ARG_W(ARG_W), .LEN_W(LEN_W),
                 .SHORT_MIN(SHORT_MIN), .LONG_MIN(LONG_MIN)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_clk(wr_clk), .ck_start(bus_wdata[CK_START]), .ck_stop(bus_wdata[CK_STOP]),
      .wr_ctrl(wr_ctrl), .new_stop(bus_wdata[CT_STOP]), .new_type(bus_wdata[1:0]),
      .new_den(bus_wdata[CT_DEN]),
      .ctrl_stop_q(ctrl_q[CT_STOP]), .ctrl_type_q(ctrl_q[1:0]), .ctrl_den_q(ctrl_q[CT_DEN]),
      .idx_q(idx_q), .arg_q(arg_q),
      .card_done(card_done), .card_rsp_len(card_rsp_len), .data_fin(data_fin),
      .card_cmd_valid(card_cmd_valid), .card_idx(card_idx), .card_arg(card_arg),
      .status(status), .active(xfer_active), .end_evt(end_evt), .data_go(data_go),
      .rsp_load(rsp_load), .rsp_load_len(rsp_load_len)
   );

   cmdseq_rspfifo #(.ENTRIES(RSP_ENTRIES), .EW(DW), .LEN_W(LEN_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .load(rsp_load), .load_len(rsp_load_len), .rsp_bytes(card_rsp_bytes),
      .pop(pop), .head(head)
   );

   assign data_write = ctrl_q[CT_DIR];

   always_comb begin
      rd_n = '0;
      case (bus_addr)
         ADR_STAT:  rd_n = status;
         ADR_CTRL:  rd_n = DW'(ctrl_q);
         ADR_IDX:   rd_n = DW'(idx_q) | (DW'(1) << IDX_W);
         ADR_ARGHI: rd_n = arg_q[ARG_W-1:DW];
         ADR_ARGLO: rd_n = arg_q[DW-1:0];
         ADR_RSP:   rd_n = head;
         default:   rd_n = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_re) bus_rdata <= rd_n;
   end

   AST_IDX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr == ADR_IDX) |=> bus_rdata[IDX_W]); // R2
   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clk && bus_wdata[CK_STOP]) |=> (!xfer_active && !status[ST_CLK])); // R14

endmodule

// File: tb/cmdseq_top_test.sv
module cmdseq_top_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_we = 1'b0, bus_re = 1'b0;
   logic [3:0]   bus_addr = '0;
   logic [15:0]  bus_wdata = '0;
   logic [15:0]  bus_rdata;
   logic         card_cmd_valid;
   logic [5:0]   card_idx;
   logic [31:0]  card_arg;
   logic         card_done = 1'b0;
   logic [4:0]   card_rsp_len = '0;
   logic [143:0] card_rsp_bytes = '0;
   logic         end_evt, data_go, data_write, xfer_active;
   logic         data_fin = 1'b0;

   always #2.5 clk = ~clk;

   cmdseq_top uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .card_cmd_valid(card_cmd_valid), .card_idx(card_idx), .card_arg(card_arg),
      .card_done(card_done), .card_rsp_len(card_rsp_len), .card_rsp_bytes(card_rsp_bytes),
      .end_evt(end_evt), .data_go(data_go), .data_write(data_write),
      .data_fin(data_fin), .xfer_active(xfer_active)
   );

   int n_chk = 0, n_fail = 0, n_end = 0, n_go = 0, n_issue = 0;
   int card_dly = 2;
   bit reported = 0;
   logic [37:0] exp_q[$];

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // driver side of the scoreboard
   task automatic expect_cmd(input logic [5:0] idx, input logic [31:0] arg);
      exp_q.push_back({idx, arg});
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      @(negedge clk); bus_re = 1'b1; bus_addr = a;
      @(negedge clk); bus_re = 1'b0; d = bus_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] e);
      logic [15:0] v;
      rd(a, v);
      check(req, v, e);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_end();
      int s = n_end;
      int g = 0;
      while (n_end == s && g < 200) begin @(negedge clk); g++; end
      if (g >= 200) check("R11 end pulse missing", 0, 1);
   endtask

   task automatic set_rsp(input int len, input logic [7:0] base);
      card_rsp_len = 5'(len);
      for (int k = 0; k < 18; k++) card_rsp_bytes[k*8 +: 8] = base + 8'(k);
   endtask

   function automatic logic [15:0] exp_entry(input int i, input int len, input logic [7:0] base);
      logic [7:0] lo, hi;
      lo = (2*i < len)     ? base + 8'(2*i)     : 8'h00;
      hi = (2*i + 1 < len) ? base + 8'(2*i + 1) : 8'h00;
      return {hi, lo};
   endfunction

   task automatic drain_chk(input string req, input int len, input logic [7:0] base);
      for (int i = 0; i < 9; i++) rd_chk(req, 4'd6, exp_entry(i, len, base));
      rd_chk({req, " drained"}, 4'd6, 16'h0000);
   endtask

   // pulse counters
   always @(negedge clk) begin
      if (end_evt) n_end++;
      if (data_go) n_go++;
   end

   // card model and monitor side of the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (card_cmd_valid) begin
            n_issue++;
            if (exp_q.size() == 0) check("R13 unexpected command", {card_idx, card_arg}, 0);
            else check("R5 issued command", {card_idx, card_arg}, exp_q.pop_front());
            repeat (card_dly) @(negedge clk);
            card_done = 1'b1;
            @(negedge clk);
            card_done = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      int go0, iss0;
      logic [15:0] v;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      check("R1 valid", card_cmd_valid, 0);
      check("R1 active", xfer_active, 0);
      rd_chk("R1 status", 4'd1, 16'h0000);
      rd_chk("R1 response", 4'd6, 16'h0000);

      // R2 index register
      wr(4'd3, 16'h00FF);
      rd_chk("R2 index", 4'd3, 16'h007F);

      // R3 argument halves
      wr(4'd4, 16'h1234);
      wr(4'd5, 16'hABCD);
      wr(4'd4, 16'h5678);
      rd_chk("R3 low kept", 4'd5, 16'hABCD);
      rd_chk("R3 high", 4'd4, 16'h5678);

      // R4 mask, R6 stop bit blocks clock-start launch
      wr(4'd2, 16'hFFFF);
      rd_chk("R4 ctrl mask", 4'd2, 16'h3DFF);
      wr(4'd0, 16'h0002);
      idle(3);
      check("R6 no launch with stop bit", card_cmd_valid, 0);
      rd_chk("R6 clock enabled", 4'd1, 16'h0100);
      wr(4'd0, 16'h0001);
      rd_chk("R14 clock off", 4'd1, 16'h0000);

      // R6 deferred launch, R9 packing, R10 read-out
      wr(4'd3, 16'h0011);
      set_rsp(6, 8'h10);
      wr(4'd2, 16'h0001);
      idle(3);
      check("R6 held while clock off", card_cmd_valid, 0);
      expect_cmd(6'h11, 32'h5678ABCD);
      wr(4'd0, 16'h0002);
      check("R6 launched by clock start", card_cmd_valid, 1);
      wait_end();
      rd_chk("R9 status end", 4'd1, 16'h2100);
      check("R12 no data phase", xfer_active, 0);
      drain_chk("R9 R10 type1 len6", 6, 8'h10);

      // R5 immediate launch, R7 status clear, R8 short type 2
      card_dly = 6;
      set_rsp(15, 8'h40);
      expect_cmd(6'h11, 32'h5678ABCD);
      wr(4'd2, 16'h0002);
      check("R5 immediate launch", card_cmd_valid, 1);
      check("R5 active", xfer_active, 1);
      rd_chk("R7 status on start", 4'd1, 16'h0100);
      go0 = n_go;
      wait_end();
      rd_chk("R8 timeout status", 4'd1, 16'h0102);
      check("R8 active low", xfer_active, 0);
      check("R8 no data start", n_go, go0);
      rd_chk("R8 store untouched", 4'd6, 16'h0000);

      // R8 R9 type 2 at its minimum
      card_dly = 2;
      set_rsp(16, 8'h80);
      expect_cmd(6'h11, 32'h5678ABCD);
      wr(4'd2, 16'h0002);
      wait_end();
      rd_chk("R8 type2 accepted", 4'd1, 16'h2100);
      drain_chk("R9 type2 len16", 16, 8'h80);

      // R8 type 3 short
      set_rsp(3, 8'h20);
      expect_cmd(6'h11, 32'h5678ABCD);
      wr(4'd2, 16'h0003);
      wait_end();
      rd_chk("R8 type3 short", 4'd1, 16'h0102);

      // R12 type 3 with data phase, finished by data engine
      set_rsp(4, 8'h30);
      expect_cmd(6'h11, 32'h5678ABCD);
      go0 = n_go;
      wr(4'd2, 16'h0007);
      wait_end();
      check("R12 data start pulse", n_go, go0 + 1);
      check("R12 active held", xfer_active, 1);
      drain_chk("R9 type3 len4", 4, 8'h30);
      @(negedge clk); data_fin = 1'b1;
      @(negedge clk); data_fin = 1'b0;
      check("R12 finish clears active", xfer_active, 0);

      // R8 R9 type 0 ignores bytes
      set_rsp(5, 8'h55);
      expect_cmd(6'h11, 32'h5678ABCD);
      wr(4'd2, 16'h0000);
      wait_end();
      rd_chk("R8 type0 accepted", 4'd1, 16'h2100);
      drain_chk("R9 type0 zero", 0, 8'h00);

      // R13 one outstanding command
      card_dly = 8;
      set_rsp(4, 8'h60);
      wr(4'd3, 16'h0005);
      expect_cmd(6'h05, 32'h5678ABCD);
      iss0 = n_issue;
      wr(4'd2, 16'h0001);
      wr(4'd3, 16'h0022);
      wr(4'd2, 16'h0005);
      check("R13 still waiting", card_cmd_valid, 1);
      check("R13 index held", card_idx, 6'h05);
      wait_end();
      idle(2);
      check("R13 single issue", n_issue, iss0 + 1);
      check("R13 nothing left running", card_cmd_valid, 0);

      // R6 held request goes out on clock start, R12 data phase
      card_dly = 2;
      expect_cmd(6'h22, 32'h5678ABCD);
      go0 = n_go;
      wr(4'd0, 16'h0002);
      wait_end();
      check("R6 held request issued", n_issue, iss0 + 2);
      check("R12 data start", n_go, go0 + 1);
      check("R12 active", xfer_active, 1);

      // R14 clock stop clears active and clock bit
      wr(4'd0, 16'h0001);
      check("R14 active cleared", xfer_active, 0);
      rd_chk("R14 status", 4'd1, 16'h2000);

      // R4 control write cancels an active transfer without launching
      wr(4'd0, 16'h0002);
      expect_cmd(6'h22, 32'h5678ABCD);
      wr(4'd2, 16'h0005);
      wait_end();
      check("R4 active before cancel", xfer_active, 1);
      wr(4'd2, 16'h0400);
      idle(2);
      check("R4 cancel clears active", xfer_active, 0);
      check("R4 stop bit no launch", card_cmd_valid, 0);
      rd(4'd2, v);
      check("R4 ctrl readback", v, 16'h0400);
      check("R5 scoreboard empty", exp_q.size(), 0);

      report();
   end

endmodule